// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block expands one block-transfer request into a stream of word transfers. A request carries a base address, a 16-bit register mask, a two-bit addressing mode, a direction (load or store) and a write-back flag. After the request is accepted, the block issues one transfer per clock. Each transfer carries a register index and a word-aligned memory address. When the stream ends, the block gives a one-cycle completion pulse. With that pulse it also gives the updated base value and its write enable, and a flag that is set when a load list contains the program counter.

The mode picks the direction of stepping: up or down. It also picks whether the step is applied before or after each word. The lowest-numbered register always takes the lowest address, so the registers are issued in ascending index order in every mode. The start address of the downward modes is derived from the mask's population count, which is computed when the request is accepted. The data movement, the register file and any change of control flow caused by loading the program counter are left to the surrounding pipeline.

Top module: `lsm_seq`

## Requirements
- R1: A request is accepted on a rising edge where `start_i` is 1 and `busy_o` is 0. `busy_o` is 1 from the next cycle until the cycle that follows the completion pulse. While `busy_o` is 1, `start_i` and every request input are ignored.
- R2: Transfers begin in the cycle right after acceptance. There is one per cycle, each marked by `xfer_valid_o`, and they run without gaps. Register indices come out in strictly ascending order and cover exactly the set bits of the mask; bit i stands for register i.
- R3: Mode 2'b00 (step up, after): the first address is the aligned base, and each later address is 4 higher.
- R4: Mode 2'b01 (step up, before): the first address is the aligned base plus 4, and each later address is 4 higher.
- R5: Mode 2'b10 (step down, after): with n set bits, the transfers cover aligned base − 4n + 4 up to the aligned base, in ascending address order.
- R6: Mode 2'b11 (step down, before): the transfers cover aligned base − 4n up to aligned base − 4, in ascending address order.
- R7: Consecutive transfers of one request have addresses exactly 4 apart, so the lowest register index lands on the lowest address. Every transfer address has its two low bits at zero.
- R8: `done_o` is high for exactly one cycle, the cycle after the last transfer. No transfer is valid in that cycle.
- R9: With `wback_i` set and a non-empty mask, `wb_en_o` is high together with `done_o`. `wb_base_o` is then the aligned base plus 4n for modes 00 and 01, or minus 4n for modes 10 and 11. In every other case `wb_en_o` stays 0.
- R10: An empty mask produces no transfers. `done_o` pulses in the cycle after acceptance, and `wb_en_o` stays 0.
- R11: The two low bits of `base_i` have no effect on any address or on the write-back value.
- R12: `pc_in_list_o` is high together with `done_o` exactly when the request was a load (`load_i`=1) and mask bit 15 was set. It is 0 at all other times.
- R13: `xfer_load_o` repeats the direction captured at acceptance on every valid transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 2 | Addressing mode: bit 1 = step down, bit 0 = step before |
| load_i | input | 1 | 1 = load, 0 = store |
| wback_i | input | 1 | Request base write-back |
| base_i | input | 32 | Base address |
| reglist_i | input | 16 | Register mask |
| busy_o | output | 1 | Sequence in progress |
| xfer_valid_o | output | 1 | Transfer strobe |
| xfer_idx_o | output | 4 | Register index of the current transfer |
| xfer_addr_o | output | 32 | Word address of the current transfer |
| xfer_load_o | output | 1 | Direction of the current transfer |
| done_o | output | 1 | Completion pulse |
| wb_en_o | output | 1 | Base write enable |
| wb_base_o | output | 32 | Updated base value |
| pc_in_list_o | output | 1 | Load list contained register 15 |

## Verification
The assertions assume that requests only arrive through the handshake. Nothing outside the block changes the sequence state once a request is accepted, so the assertions only have to cover ordering, spacing and pulse shape. The stepping assertion also assumes that consecutive valid beats belong to one request, which holds because every request ends with a completion cycle that carries no transfer. The stimulus drives each request for one cycle at acceptance. In some runs it then holds `start_i` high with unrelated values for the whole sequence, to show that a request made while busy is dropped. Bases are chosen near zero and near the top of the address space, so wrap-around follows plain modular arithmetic.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  // bit 1: step down, bit 0: step applied before the word
  typedef enum logic [1:0] {
    LSM_UP_AFTER  = 2'b00,
    LSM_UP_BEFORE = 2'b01,
    LSM_DN_AFTER  = 2'b10,
    LSM_DN_BEFORE = 2'b11
  } lsm_mode_e;

  function automatic logic mode_is_down(input lsm_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_before(input lsm_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] partial [0:NREG];

  assign partial[0] = '0;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_sum
      assign partial[g+1] = partial[g] + CNT_W'(mask_i[g]);
    end
  endgenerate

  assign count_o = partial[NREG];

endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  onehot_o
);

  // isolate lowest set bit by two's complement
  assign onehot_o = mask_i & (~mask_i + NREG'(1));
  assign any_o    = |mask_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = $clog2(NREG + 1)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  lsm_mode_e         mode_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] final_base_o
);

  localparam int STEP_SH                = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(WORD_BYTES);

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:STEP_SH], {STEP_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] span(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) << STEP_SH;
  endfunction

  function automatic logic [ADDR_W-1:0] first_of(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0] n,
                                                  input lsm_mode_e m);
    logic [ADDR_W-1:0] lo;
    if (!mode_is_down(m)) lo = b;
    else                  lo = b - span(n);
    // up-before and down-after both shift the window one word up
    if (mode_is_down(m) != mode_is_before(m)) lo = lo + STEP_V;
    return lo;
  endfunction

  function automatic logic [ADDR_W-1:0] final_of(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0] n,
                                                  input lsm_mode_e m);
    return mode_is_down(m) ? (b - span(n)) : (b + span(n));
  endfunction

  logic [ADDR_W-1:0] base_al;

  assign base_al      = align(base_i);
  assign first_addr_o = first_of(base_al, count_i, mode_i);
  assign final_base_o = final_of(base_al, count_i, mode_i);

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              wback_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   reglist_i,
  output logic              busy_o,
  output logic              xfer_valid_o,
  output logic [IDX_W-1:0]  xfer_idx_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_load_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              pc_in_list_o
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(WORD_BYTES);
  localparam int PC_IDX                = NREG - 1;

  // ---- named internal events ----
  logic              accept;
  logic              beat;
  logic              finish;
  logic [CNT_W-1:0]  req_count;
  logic [ADDR_W-1:0] req_first;
  logic [ADDR_W-1:0] req_final;
  logic              pend_any;
  logic [IDX_W-1:0]  pend_idx;
  logic [NREG-1:0]   pend_lsb;

  // ---- state ----
  logic              busy_q;
  logic [NREG-1:0]   pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_q;
  logic              wb_req_q;
  logic [ADDR_W-1:0] wb_val_q;
  logic              pc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  beats_q;

  lsm_popcount #(.NREG(NREG), .CNT_W(CNT_W)) u_count (
    .mask_i  (reglist_i),
    .count_o (req_count)
  );

  lsm_addr_gen #(
    .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
  ) u_addr (
    .base_i       (base_i),
    .count_i      (req_count),
    .mode_i       (lsm_mode_e'(mode_i)),
    .first_addr_o (req_first),
    .final_base_o (req_final)
  );

  lsm_lowest #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .mask_i   (pend_q),
    .any_o    (pend_any),
    .idx_o    (pend_idx),
    .onehot_o (pend_lsb)
  );

  assign accept = start_i & ~busy_q;
  assign beat   = busy_q & pend_any;
  assign finish = busy_q & ~pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pend_q   <= '0;
      addr_q   <= '0;
      load_q   <= 1'b0;
      wb_req_q <= 1'b0;
      wb_val_q <= '0;
      pc_q     <= 1'b0;
      cnt_q    <= '0;
      beats_q  <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      pend_q   <= reglist_i;
      addr_q   <= req_first;
      load_q   <= load_i;
      wb_req_q <= wback_i & (|reglist_i);
      wb_val_q <= req_final;
      pc_q     <= load_i & reglist_i[PC_IDX];
      cnt_q    <= req_count;
      beats_q  <= '0;
    end else if (beat) begin
      pend_q   <= pend_q & ~pend_lsb;
      addr_q   <= addr_q + STEP_V;
      beats_q  <= beats_q + CNT_W'(1);
    end else if (finish) begin
      busy_q   <= 1'b0;
    end
  end

  assign busy_o       = busy_q;
  assign xfer_valid_o = beat;
  assign xfer_idx_o   = pend_idx;
  assign xfer_addr_o  = addr_q;
  assign xfer_load_o  = load_q;
  assign done_o       = finish;
  assign wb_en_o      = finish & wb_req_q;
  assign wb_base_o    = wb_val_q;
  assign pc_in_list_o = finish & pc_q;

  // ---- assertions ----
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xfer_valid_o && !done_o)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R1

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o)) |-> (xfer_idx_o > $past(xfer_idx_o))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o)) |-> (xfer_addr_o == $past(xfer_addr_o) + STEP_V)); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (xfer_addr_o[1:0] == 2'b00)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R8

  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (beats_q == cnt_q)); // R2

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o); // R9

  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_in_list_o |-> (done_o && xfer_load_o)); // R12

endmodule

// File: tb/lsm_seq_test.sv
module lsm_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        load_i = 1'b0;
  logic        wback_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reglist_i = '0;
  logic        busy_o, xfer_valid_o, xfer_load_o, done_o, wb_en_o, pc_in_list_o;
  logic [3:0]  xfer_idx_o;
  logic [31:0] xfer_addr_o, wb_base_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  lsm_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .load_i(load_i), .wback_i(wback_i), .base_i(base_i), .reglist_i(reglist_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_idx_o(xfer_idx_o),
    .xfer_addr_o(xfer_addr_o), .xfer_load_o(xfer_load_o), .done_o(done_o),
    .wb_en_o(wb_en_o), .wb_base_o(wb_base_o), .pc_in_list_o(pc_in_list_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: a request expands into a queue of (index, address) pairs.
  task automatic run(input logic [1:0] mode, input bit ld, input bit wb,
                     input logic [31:0] base, input logic [15:0] list,
                     input bit junk, input string tag);
    int          idxq[$];
    logic [31:0] lo, hi, al, fin;
    int          n;
    for (int i = 0; i < 16; i++) if (list[i]) idxq.push_back(i);
    n  = idxq.size();
    al = base & 32'hFFFF_FFFC;
    case (mode)
      2'b00: lo = al;
      2'b01: lo = al + 32'd4;
      2'b10: lo = al - 32'(4 * n) + 32'd4;
      default: lo = al - 32'(4 * n);
    endcase
    hi  = lo + 32'(4 * (n > 0 ? n - 1 : 0));
    fin = (mode[1]) ? al - 32'(4 * n) : al + 32'(4 * n);

    @(negedge clk);
    start_i = 1'b1; mode_i = mode; load_i = ld; wback_i = wb;
    base_i = base; reglist_i = list;
    @(negedge clk);
    if (junk) begin
      // R1: a request presented while busy must be dropped
      start_i = 1'b1; mode_i = ~mode; load_i = ~ld; wback_i = 1'b1;
      base_i = 32'h0000_8000; reglist_i = 16'h5A5A;
    end else begin
      start_i = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      chk(busy_o === 1'b1, {"R1 busy ", tag}, 32'(busy_o), 32'd1);
      chk(xfer_valid_o === 1'b1, {"R2 valid ", tag}, 32'(xfer_valid_o), 32'd1);
      chk(xfer_idx_o === 4'(idxq[k]), {"R2 index ", tag}, 32'(xfer_idx_o), 32'(idxq[k]));
      chk(xfer_addr_o === lo + 32'(4 * k), {"R3-6 addr ", tag}, xfer_addr_o, lo + 32'(4 * k));
      chk(xfer_load_o === ld, {"R13 dir ", tag}, 32'(xfer_load_o), 32'(ld));
      chk(done_o === 1'b0, {"R8 early done ", tag}, 32'(done_o), 32'd0);
      @(negedge clk);
    end
    // completion cycle
    chk(done_o === 1'b1, {"R8 done ", tag}, 32'(done_o), 32'd1);
    chk(xfer_valid_o === 1'b0, {"R8 no beat at done ", tag}, 32'(xfer_valid_o), 32'd0);
    chk(wb_en_o === (wb && n > 0), {"R9 wb_en ", tag}, 32'(wb_en_o), 32'(wb && n > 0));
    if (wb && n > 0)
      chk(wb_base_o === fin, {"R9 wb value ", tag}, wb_base_o, fin);
    chk(pc_in_list_o === (ld && list[15]), {"R12 pc flag ", tag},
        32'(pc_in_list_o), 32'(ld && list[15]));
    if (n > 0) begin
      chk(lo[1:0] == 2'b00 && hi[1:0] == 2'b00, {"R7 aligned ", tag}, lo, hi);
    end
    start_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && xfer_valid_o === 1'b0,
        {"R1 idle after ", tag}, {29'd0, busy_o, done_o, xfer_valid_o}, 32'd0);
    chk(pc_in_list_o === 1'b0 && wb_en_o === 1'b0, {"R12 flags clear ", tag},
        {30'd0, pc_in_list_o, wb_en_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && xfer_valid_o === 1'b0 && done_o === 1'b0,
        "R1 reset state", {29'd0, busy_o, xfer_valid_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && wb_en_o === 1'b0 && pc_in_list_o === 1'b0,
        "R1 idle after reset", {29'd0, busy_o, wb_en_o, pc_in_list_o}, 32'd0);

    run(2'b00, 1'b0, 1'b1, 32'h0000_1000, 16'h0023, 1'b0, "R3 up-after");
    run(2'b01, 1'b0, 1'b1, 32'h0000_1000, 16'h0023, 1'b0, "R4 up-before");
    run(2'b10, 1'b1, 1'b1, 32'h0000_1000, 16'h0023, 1'b0, "R5 down-after");
    run(2'b11, 1'b1, 1'b1, 32'h0000_1000, 16'h0023, 1'b0, "R6 down-before");
    run(2'b00, 1'b1, 1'b0, 32'h0000_2000, 16'h8003, 1'b0, "R12 load with pc");
    run(2'b11, 1'b0, 1'b1, 32'h0000_2000, 16'h8000, 1'b0, "R12 store with pc");
    run(2'b01, 1'b1, 1'b1, 32'h0000_3000, 16'h0000, 1'b0, "R10 empty list");
    run(2'b10, 1'b0, 1'b1, 32'h0000_3003, 16'h0421, 1'b0, "R11 misaligned base");
    run(2'b00, 1'b1, 1'b1, 32'h0000_4001, 16'hFFFF, 1'b0, "R11 full list");
    run(2'b11, 1'b1, 1'b1, 32'hFFFF_FFFC, 16'hFFFF, 1'b0, "R6 full list down");
    run(2'b11, 1'b0, 1'b1, 32'h0000_0008, 16'h0007, 1'b0, "R6 wrap below zero");
    run(2'b01, 1'b0, 1'b1, 32'hFFFF_FFF8, 16'h0003, 1'b0, "R4 wrap above top");
    run(2'b10, 1'b1, 1'b0, 32'h0000_5000, 16'h1248, 1'b1, "R1 start while busy");
    run(2'b00, 1'b0, 1'b1, 32'h0000_6000, 16'h0000, 1'b1, "R10 empty while busy");
    run(2'b01, 1'b1, 1'b0, 32'h0000_7002, 16'h4001, 1'b0, "R13 load no wb");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule